// File: doc/BRIEF.md
# Answer-to-Reset Window Supervisor

This block supervises a smart card's answer-to-reset phase. Once the card clock has started, it counts card clock cycles and drives the card reset line. It also watches the card I/O line for the falling edge of a start bit and decides whether the card answered too soon, in time, or not at all. Card clock cycles are presented as a one-cycle enable on the system clock. The I/O level is sampled only on those enabled cycles.

A cold start begins a count with reset held low. A falling edge seen in the earliest part of that count is disregarded. A falling edge in the next part of the window ends the sequence and flags an early answer. A later falling edge ends the sequence as a normal answer, and reset stays low. If no answer arrives within the full window, the block raises reset and counts a second window. In that window a quick answer is flagged early, and silence marks the card mute.

When the sequence ends, the block pulses a clear for the warm-reset request bit. A warm request on an answered card restarts the same windowed procedure with reset low. An abort from the deactivation sequencer takes the block back to idle at any time.

Top module: `atr_reset_monitor`

## Requirements
- R1: After reset, card_rst, early_flag, mute_flag, done and warm_clr are all 0.
- R2: In the reset-low phase, a falling edge judged at count value below IGNORE_CLKS is disregarded. The sequence then carries on exactly as if no edge had occurred.
- R3: In the reset-low phase, a falling edge judged at count value c with IGNORE_CLKS <= c < EARLY_CLKS sets early_flag and ends the sequence (done = 1).
- R4: In the reset-low phase, a falling edge judged at count value c with EARLY_CLKS <= c < WINDOW_CLKS ends the sequence with early_flag = 0. card_rst never rises, and the count stops.
- R5: If no answer arrives in the reset-low phase, card_rst rises at the enabled edge with count value WINDOW_CLKS-1, which is the WINDOW_CLKS-th enabled card clock. The count then restarts from 0.
- R6: In the reset-high phase, a falling edge judged at count value c ends the sequence. early_flag is set if c < EARLY_CLKS and cleared otherwise.
- R7: If no answer arrives within WINDOW_CLKS enabled clocks of the reset-high phase, mute_flag and done are set.
- R8: warm_clr is a single-cycle pulse, issued on the same edge at which the sequence ends, whether by an answer or by mute.
- R9: A warm_req high while the sequence is finished (done = 1) drives card_rst low, clears both flags and done, and reruns the windowed procedure from count 0.
- R10: While abort is high, card_rst is 0 in that same cycle. On the following edge the block is idle with its count cleared, so the next cold start is timed afresh.
- R11: Only cycles with card_clk_en = 1 advance the count or sample io_level. The count value at which a falling edge is judged is the one in effect at the third enabled edge that samples io_level low, because the edge passes through a two-stage synchronizer.
- R12: cold_start is accepted only while idle. A cold_start during a running sequence has no effect on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_clk_en | input | 1 | One-cycle strobe per card clock cycle |
| io_level | input | 1 | Filtered level of the card I/O line |
| cold_start | input | 1 | Request to begin a cold answer-to-reset sequence |
| warm_req | input | 1 | Warm-reset request bit level |
| abort | input | 1 | Synchronous abort from deactivation |
| card_rst | output | 1 | Reset line toward the card |
| early_flag | output | 1 | Card answered inside the early window |
| mute_flag | output | 1 | Card gave no answer in either window |
| done | output | 1 | Sequence finished (answer or mute) |
| warm_clr | output | 1 | Pulse clearing the warm-reset request bit |

## Verification
The assertions assume that io_level changes only between enabled card clock edges and that warm_req is dropped once warm_clr has been seen. They also assume that abort and cold_start are single-cycle or level requests aligned to the system clock. The stimulus drops the I/O line at a chosen enabled-edge index and holds it low until the sequence ends. It raises the line again only after an abort, with several enabled edges to flush the synchronizer before the next start. The answer position is swept over every count value of both phases, with the enable strobe first continuous and then at half rate.

// File: rtl/atr_mon_pkg.sv
package atr_mon_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RST_LOW  = 2'd1,
        ST_RST_HIGH = 2'd2,
        ST_DONE     = 2'd3
    } atr_state_e;

endpackage

// File: rtl/atr_io_edge.sv
module atr_io_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_clk_en,
    input  logic io_level,
    output logic io_fall
);

    localparam int HIST_W = SYNC_STAGES + 1;

    logic [HIST_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (card_clk_en) begin
            sh_d = {sh_q[HIST_W-2:0], io_level};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    // Fall seen when the oldest history bit is high and the synchronized level is low.
    assign io_fall = card_clk_en & sh_q[HIST_W-1] & ~sh_q[HIST_W-2];

    // R11: history only moves on enabled card clock cycles
    a_r11_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !card_clk_en |=> $stable(sh_q));

endmodule

// File: rtl/atr_seq.sv
module atr_seq
    import atr_mon_pkg::*;
#(
    parameter int IGNORE_CLKS = 200,
    parameter int EARLY_CLKS  = 352,
    parameter int WINDOW_CLKS = 41950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_clk_en,
    input  logic io_fall,
    input  logic cold_start,
    input  logic warm_req,
    input  logic abort,
    output logic card_rst,
    output logic early_flag,
    output logic mute_flag,
    output logic done,
    output logic warm_clr
);

    localparam int CNT_W = $clog2(WINDOW_CLKS + 1);
    localparam logic [CNT_W-1:0] IGN_C  = CNT_W'(IGNORE_CLKS);
    localparam logic [CNT_W-1:0] ERL_C  = CNT_W'(EARLY_CLKS);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WINDOW_CLKS - 1);

    typedef struct packed {
        atr_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             rst;
        logic             early;
        logic             mute;
        logic             warm_clr;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.warm_clr = 1'b0;
        if (abort) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
            r_d.rst   = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (cold_start) begin
                        r_d.state = ST_RST_LOW;
                        r_d.cnt   = '0;
                        r_d.rst   = 1'b0;
                        r_d.early = 1'b0;
                        r_d.mute  = 1'b0;
                    end
                end
                ST_RST_LOW: begin
                    if (card_clk_en) begin
                        if (io_fall && (r_q.cnt >= IGN_C)) begin
                            r_d.state    = ST_DONE;
                            r_d.early    = (r_q.cnt < ERL_C);
                            r_d.warm_clr = 1'b1;
                        end else if (r_q.cnt == LAST_C) begin
                            r_d.state = ST_RST_HIGH;
                            r_d.cnt   = '0;
                            r_d.rst   = 1'b1;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_RST_HIGH: begin
                    if (card_clk_en) begin
                        if (io_fall) begin
                            r_d.state    = ST_DONE;
                            r_d.early    = (r_q.cnt < ERL_C);
                            r_d.warm_clr = 1'b1;
                        end else if (r_q.cnt == LAST_C) begin
                            r_d.state    = ST_DONE;
                            r_d.mute     = 1'b1;
                            r_d.warm_clr = 1'b1;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    if (warm_req) begin
                        r_d.state = ST_RST_LOW;
                        r_d.cnt   = '0;
                        r_d.rst   = 1'b0;
                        r_d.early = 1'b0;
                        r_d.mute  = 1'b0;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, rst: 1'b0, early: 1'b0,
                     mute: 1'b0, warm_clr: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign card_rst   = r_q.rst & ~abort;
    assign early_flag = r_q.early;
    assign mute_flag  = r_q.mute;
    assign done       = (r_q.state == ST_DONE);
    assign warm_clr   = r_q.warm_clr;

    // R2: an edge inside the ignore window never ends the reset-low phase
    a_r2_ignore_window: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RST_LOW && io_fall && r_q.cnt < IGN_C)
        |=> (r_q.state != ST_DONE));

    // R3, R6: early flag only rises on an edge judged below the early limit
    a_r3_early_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.early) |-> ($past(r_q.cnt) < ERL_C));

    // R5: counter never passes the last window value
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST_C);

    // R7: mute only follows the reset-high phase
    a_r7_mute_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.mute) |-> ($past(r_q.state) == ST_RST_HIGH));

    // R8: warm clear is a single-cycle pulse landing in the finished state
    a_r8_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.warm_clr |=> !r_q.warm_clr);
    a_r8_clear_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.warm_clr |-> (r_q.state == ST_DONE));

    // R10: abort leaves the block idle, count cleared, reset low
    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (r_q.state == ST_IDLE && r_q.cnt == '0 && !r_q.rst));

endmodule

// File: rtl/atr_reset_monitor.sv
module atr_reset_monitor #(
    parameter int IGNORE_CLKS = 200,
    parameter int EARLY_CLKS  = 352,
    parameter int WINDOW_CLKS = 41950,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_clk_en,
    input  logic io_level,
    input  logic cold_start,
    input  logic warm_req,
    input  logic abort,
    output logic card_rst,
    output logic early_flag,
    output logic mute_flag,
    output logic done,
    output logic warm_clr
);

    logic io_fall;

    atr_io_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .card_clk_en(card_clk_en),
        .io_level   (io_level),
        .io_fall    (io_fall)
    );

    atr_seq #(
        .IGNORE_CLKS(IGNORE_CLKS),
        .EARLY_CLKS (EARLY_CLKS),
        .WINDOW_CLKS(WINDOW_CLKS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .card_clk_en(card_clk_en),
        .io_fall    (io_fall),
        .cold_start (cold_start),
        .warm_req   (warm_req),
        .abort      (abort),
        .card_rst   (card_rst),
        .early_flag (early_flag),
        .mute_flag  (mute_flag),
        .done       (done),
        .warm_clr   (warm_clr)
    );

endmodule

// File: tb/atr_reset_monitor_tb.sv
module atr_reset_monitor_tb;

    localparam int IGN = 4;
    localparam int ERL = 7;
    localparam int WIN = 20;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, card_clk_en, io_level, cold_start, warm_req, abort;
    logic card_rst, early_flag, mute_flag, done, warm_clr;

    atr_reset_monitor #(
        .IGNORE_CLKS(IGN),
        .EARLY_CLKS (ERL),
        .WINDOW_CLKS(WIN),
        .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .card_clk_en(card_clk_en), .io_level(io_level),
        .cold_start(cold_start), .warm_req(warm_req), .abort(abort),
        .card_rst(card_rst), .early_flag(early_flag), .mute_flag(mute_flag),
        .done(done), .warm_clr(warm_clr)
    );

    int tests = 0;
    int fails = 0;
    int k, done_at, rst_at, clr_n, clr_at;
    logic rst_prev, done_prev;
    bit finished = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic en);
        card_clk_en = en;
        @(posedge clk);
        @(negedge clk);
        card_clk_en = 1'b0;
        if (en) k++;
        if (card_rst && !rst_prev && rst_at < 0) rst_at = k - 1;
        rst_prev = card_rst;
        if (done && !done_prev && done_at < 0) done_at = k - 1;
        done_prev = done;
        if (warm_clr) begin
            clr_n++;
            clr_at = k - 1;
            warm_req = 1'b0;
        end
    endtask

    task automatic clear_rec();
        k = 0; rst_at = -1; done_at = -1; clr_n = 0; clr_at = -1;
        rst_prev = card_rst; done_prev = done;
    endtask

    task automatic start_seq();
        cold_start = 1'b1;
        step(1'b0);
        cold_start = 1'b0;
        clear_rec();
    endtask

    task automatic finish_case();
        abort = 1'b1;
        step(1'b0);
        abort = 1'b0;
        io_level = 1'b1;
        repeat (4) step(1'b1);
    endtask

    // Answer judged at enabled-edge index p (counted from the cold start).
    task automatic run_case(input int p, input int div);
        int cyc = 0;
        bit dropped = 1'b0;
        int e_done, e_rst, e_early, e_mute;
        string t;
        start_seq();
        while (done_at < 0 && k < 2 * WIN + 4) begin
            if (!dropped && k == p - 2) begin
                io_level = 1'b0;
                dropped = 1'b1;
            end
            step((div == 1) || (cyc % 2 == 0));
            cyc++;
        end
        if (p < WIN && p >= IGN) begin
            e_done = p; e_rst = -1; e_early = (p < ERL); e_mute = 0;
            t = (p < ERL) ? "R3 R11" : "R4 R11";
        end else if (p < WIN) begin
            e_done = 2 * WIN - 1; e_rst = WIN - 1; e_early = 0; e_mute = 1;
            t = "R2";
        end else if (p < 2 * WIN) begin
            e_done = p; e_rst = WIN - 1; e_early = ((p - WIN) < ERL); e_mute = 0;
            t = "R6 R11";
        end else begin
            e_done = 2 * WIN - 1; e_rst = WIN - 1; e_early = 0; e_mute = 1;
            t = "R7";
        end
        chk({t, " done index"}, done_at, e_done);
        chk("R5 reset rise index", rst_at, e_rst);
        chk({t, " early flag"}, int'(early_flag), e_early);
        chk("R7 mute flag", int'(mute_flag), e_mute);
        chk("R8 clear pulse count", clr_n, 1);
        chk("R8 clear pulse index", clr_at, e_done);
        finish_case();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; card_clk_en = 1'b0; io_level = 1'b1;
        cold_start = 1'b0; warm_req = 1'b0; abort = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 card_rst", int'(card_rst), 0);
        chk("R1 early_flag", int'(early_flag), 0);
        chk("R1 mute_flag", int'(mute_flag), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 warm_clr", int'(warm_clr), 0);
        rst_n = 1'b1;
        clear_rec();
        repeat (4) step(1'b1);

        // Sweep the answer position over both phases, full and half-rate enable.
        for (int div = 1; div <= 2; div++) begin
            for (int p = 2; p <= 2 * WIN + 1; p++) begin
                run_case(p, div);
            end
        end

        // R9: warm request after an answered sequence reruns the window.
        start_seq();
        while (done_at < 0 && k < 2 * WIN + 4) begin
            if (k == 8) io_level = 1'b0;
            step(1'b1);
        end
        chk("R4 answered before warm", done_at, 10);
        io_level = 1'b1;
        repeat (4) step(1'b1);
        warm_req = 1'b1;
        step(1'b0);
        chk("R9 reset low after warm", int'(card_rst), 0);
        chk("R9 done cleared", int'(done), 0);
        chk("R9 early cleared", int'(early_flag), 0);
        clear_rec();
        while (done_at < 0 && k < 2 * WIN + 4) step(1'b1);
        chk("R9 reset rise after warm", rst_at, WIN - 1);
        chk("R9 mute after warm", done_at, 2 * WIN - 1);
        chk("R8 warm clear on mute", clr_at, 2 * WIN - 1);
        chk("R8 warm request dropped", int'(warm_req), 0);
        finish_case();

        // R10: abort in the reset-high phase, then a fresh cold start.
        start_seq();
        repeat (WIN + 3) step(1'b1);
        chk("R10 reset high before abort", int'(card_rst), 1);
        abort = 1'b1;
        #1;
        chk("R10 reset low in abort cycle", int'(card_rst), 0);
        step(1'b0);
        abort = 1'b0;
        chk("R10 idle after abort", int'(done), 0);
        chk("R10 reset stays low", int'(card_rst), 0);
        start_seq();
        while (done_at < 0 && k < 2 * WIN + 4) step(1'b1);
        chk("R10 fresh count reset rise", rst_at, WIN - 1);
        finish_case();

        // R12: cold start during a running sequence is ignored.
        start_seq();
        repeat (5) step(1'b1);
        cold_start = 1'b1;
        step(1'b1);
        cold_start = 1'b0;
        while (done_at < 0 && k < 2 * WIN + 4) step(1'b1);
        chk("R12 reset rise unchanged", rst_at, WIN - 1);
        chk("R12 mute index unchanged", done_at, 2 * WIN - 1);
        finish_case();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule